// File: doc/BRIEF.md
# Serial Flash Status Poll Master

This block is an SPI master that asks a serial flash device for its status byte and tells a host whether the device is ready. A one-cycle `start` pulse begins a transaction. The master drops chip select and shifts out the status-read opcode. It then gives one spare clock with nothing captured, and reads the eight status bits that follow. The transaction ends with a one-cycle `done` pulse. The raw byte and three decoded flags are then held at the outputs until the next start.

With `poll_en` set at start, the master repeats the read until the device reports ready. Between attempts it releases chip select for one SCK half-period. It stops after `try_limit` attempts, and in that case it raises `timeout`. The bus runs in SPI mode 0. The SCK half-period is `DIV_HALF` system clocks.

Top module: `flash_status_poller`

## Requirements
- R1: While `rst` is high and after it is released, `cs_n`=1, `sck`=0, `mosi`=0, `busy`=0, `done`=0, `status`=0 and all flags are 0.
- R2: Each attempt drives the opcode 0x57 on `mosi`, MSB first, on SCK rising edges 1 to 8. `mosi` changes only while `sck` is low, and it is 0 after the opcode.
- R3: Each attempt has exactly 17 SCK rising edges. Edge 9 captures nothing. `miso` is sampled on rising edges 10 to 17, and edge 10 holds status bit 7.
- R4: SCK idles low and is low whenever `cs_n` is high. Every SCK high phase and low phase inside a frame lasts `DIV_HALF` system clocks.
- R5: `cs_n` falls `DIV_HALF` system clocks before the first SCK rising edge. It rises `DIV_HALF` system clocks after the last SCK falling edge.
- R6: `ready` is status bit 7 (1 = device ready). `cmp_flag` is status bit 6.
- R7: `density_bad` is 1 exactly when status bits 5:3 differ from binary 100. Status bits 2:0 have no effect on any flag.
- R8: `done` is high for one cycle, in the cycle where `busy` drops. `status` and the flags hold from then until the next accepted start. A `start` pulse while `busy` is high is ignored.
- R9: In poll mode the read repeats until status bit 7 is 1. Between attempts `cs_n` stays high for `DIV_HALF` system clocks.
- R10: In poll mode, after `try_limit` attempts that are not ready, the master finishes with `timeout`=1. A limit of 0 acts as 1. Without poll mode there is exactly one attempt, and `timeout` is 0.
- R11: `miso` is ignored during the opcode clocks and during the spare clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a read |
| poll_en | input | 1 | Repeat until ready (latched at start) |
| try_limit | input | TRY_W | Maximum attempts in poll mode (latched at start) |
| miso | input | 1 | Serial data from flash |
| sck | output | 1 | Serial clock, mode 0 |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to flash |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 8 | Last status byte captured |
| ready | output | 1 | Status bit 7 |
| cmp_flag | output | 1 | Status bit 6 |
| density_bad | output | 1 | Density field mismatch |
| timeout | output | 1 | Poll limit reached without ready |

## Verification
The bench builds the block with `DIV_HALF`=3, an odd value above the minimum. This exposes any counter that mixes up the two SCK phases or the lead and trail gaps. With `TRY_W`=4, limits of 0, 3 and 5 all fit in the port. Both the early-ready and the timeout exits of the poll loop are reached in a few hundred cycles. The device model drives the complement of the first status bit before the spare clock, so a capture that starts one edge early shows up in `status`.

// File: rtl/sfsp_pkg.sv
package sfsp_pkg;

    localparam logic [7:0] OPC_STATUS   = 8'h57;
    localparam logic [2:0] DENSITY_CODE = 3'b100;
    localparam int         FRAME_CLKS   = 17;
    localparam int         RX_FIRST_IX  = 9;   // zero-based index of first captured clock

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_HIGH,
        PH_LOW,
        PH_TRAIL,
        PH_GAP
    } phase_t;

    typedef struct packed {
        logic ready;
        logic cmp;
        logic dens_bad;
    } flags_t;

    function automatic flags_t decode_status(input logic [7:0] s);
        flags_t f;
        f.ready    = s[7];
        f.cmp      = s[6];
        f.dens_bad = (s[5:3] != DENSITY_CODE);
        return f;
    endfunction

endpackage

// File: rtl/sfsp_half_timer.sv
module sfsp_half_timer #(
    parameter int DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV_HALF > 2) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)     cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);  // R4

endmodule

// File: rtl/sfsp_rx_shift.sv
module sfsp_rx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst || clr) q <= '0;
        else if (en)    q <= {q[W-2:0], din};
    end
endmodule

// File: rtl/sfsp_decode.sv
module sfsp_decode
    import sfsp_pkg::*;
(
    input  logic [7:0] raw,
    output flags_t     flags
);
    always_comb flags = decode_status(raw);
endmodule

// File: rtl/flash_status_poller.sv
module flash_status_poller
    import sfsp_pkg::*;
#(
    parameter int DIV_HALF = 4,
    parameter int TRY_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             poll_en,
    input  logic [TRY_W-1:0] try_limit,
    input  logic             miso,
    output logic             sck,
    output logic             cs_n,
    output logic             mosi,
    output logic             busy,
    output logic             done,
    output logic [7:0]       status,
    output logic             ready,
    output logic             cmp_flag,
    output logic             density_bad,
    output logic             timeout
);
    localparam logic [4:0] LAST_IX  = 5'(FRAME_CLKS - 1);
    localparam logic [4:0] RX_IX    = 5'(RX_FIRST_IX);

    phase_t           ph;
    logic [4:0]       clk_ix;
    logic [7:0]       op_sh;
    logic [TRY_W-1:0] tries, lim_q;
    logic             poll_q;
    logic             sck_q, cs_q, done_q, to_q;
    logic [7:0]       status_q;
    flags_t           flags_q, fl_now;
    logic             tick, run, sample_en, rx_clr, accept;
    logic [7:0]       rx;

    assign run       = (ph != PH_IDLE);
    assign accept    = (ph == PH_IDLE) && start;
    assign sample_en = tick && (ph == PH_LEAD || ph == PH_LOW) && (clk_ix >= RX_IX);
    assign rx_clr    = accept || (ph == PH_GAP && tick);

    sfsp_half_timer #(.DIV_HALF(DIV_HALF)) u_timer (
        .clk(clk), .rst(rst), .run(run), .tick(tick)
    );

    sfsp_rx_shift #(.W(8)) u_rx (
        .clk(clk), .rst(rst), .clr(rx_clr), .en(sample_en), .din(miso), .q(rx)
    );

    sfsp_decode u_dec (.raw(rx), .flags(fl_now));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            clk_ix   <= '0;
            op_sh    <= '0;
            tries    <= '0;
            lim_q    <= '0;
            poll_q   <= 1'b0;
            sck_q    <= 1'b0;
            cs_q     <= 1'b1;
            done_q   <= 1'b0;
            to_q     <= 1'b0;
            status_q <= '0;
            flags_q  <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (ph)
                PH_IDLE: if (start) begin
                    ph     <= PH_LEAD;
                    cs_q   <= 1'b0;
                    clk_ix <= '0;
                    op_sh  <= OPC_STATUS;
                    tries  <= TRY_W'(1);
                    poll_q <= poll_en;
                    lim_q  <= (try_limit == '0) ? TRY_W'(1) : try_limit;
                end
                PH_LEAD, PH_LOW: if (tick) begin
                    sck_q <= 1'b1;
                    ph    <= PH_HIGH;
                end
                PH_HIGH: if (tick) begin
                    sck_q  <= 1'b0;
                    op_sh  <= {op_sh[6:0], 1'b0};
                    clk_ix <= clk_ix + 1'b1;
                    ph     <= (clk_ix == LAST_IX) ? PH_TRAIL : PH_LOW;
                end
                PH_TRAIL: if (tick) begin
                    cs_q <= 1'b1;
                    if (poll_q && !fl_now.ready && (tries < lim_q)) begin
                        tries <= tries + 1'b1;
                        ph    <= PH_GAP;
                    end else begin
                        ph       <= PH_IDLE;
                        done_q   <= 1'b1;
                        status_q <= rx;
                        flags_q  <= fl_now;
                        to_q     <= poll_q && !fl_now.ready;
                    end
                end
                PH_GAP: if (tick) begin
                    cs_q   <= 1'b0;
                    clk_ix <= '0;
                    op_sh  <= OPC_STATUS;
                    ph     <= PH_LEAD;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign sck         = sck_q;
    assign cs_n        = cs_q;
    assign mosi        = op_sh[7];
    assign busy        = run;
    assign done        = done_q;
    assign status      = status_q;
    assign ready       = flags_q.ready;
    assign cmp_flag    = flags_q.cmp;
    assign density_bad = flags_q.dens_bad;
    assign timeout     = to_q;

    AST_SCK_LOW_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck);  // R4
    AST_MOSI_HELD_WHILE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (sck && $past(sck)) |-> $stable(mosi));  // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R8
    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);  // R8
    AST_STATUS_HELD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(status));  // R8
    AST_TIMEOUT_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        timeout |-> !ready);  // R10

endmodule

// File: tb/flash_status_poller_test.sv
module flash_status_poller_test;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 3;
    localparam int TW         = 4;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, poll_en = 1'b0, miso = 1'b0;
    logic [TW-1:0] try_limit = '0;
    logic sck, cs_n, mosi, busy, done, ready, cmp_flag, density_bad, timeout;
    logic [7:0] status;

    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_status_poller #(.DIV_HALF(DIV), .TRY_W(TW)) uut (
        .clk(clk), .rst(rst), .start(start), .poll_en(poll_en), .try_limit(try_limit),
        .miso(miso), .sck(sck), .cs_n(cs_n), .mosi(mosi), .busy(busy), .done(done),
        .status(status), .ready(ready), .cmp_flag(cmp_flag),
        .density_bad(density_bad), .timeout(timeout)
    );

    // Device model and bus monitor
    logic [7:0] resp [8];
    int cyc = 0, frames = 0, rises = 0;
    int t_csfall = 0, t_csrise = 0, t_edge = 0, t_lastfall = 0;
    int gap_bad = 0, lead_bad = 0, trail_bad = 0, hp_bad = 0, len_bad = 0;
    int op_bad = 0, mosi_bad = 0, cs_bad = 0, tail_bad = 0;
    logic prev_sck = 1'b0, prev_cs = 1'b1, prev_mosi = 1'b0;
    logic [7:0] op_rx = '0;

    function automatic logic [7:0] cur_resp();
        int ix = (frames < 1) ? 0 : ((frames > 8) ? 7 : frames - 1);
        return resp[ix];
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (prev_cs && !cs_n) begin
            frames++;
            rises = 0;
            if (frames > 1 && (cyc - t_csrise) != DIV) gap_bad++;
            t_csfall = cyc;
            miso = 1'b1;
        end
        if (!prev_cs && cs_n) begin
            t_csrise = cyc;
            if ((cyc - t_lastfall) != DIV) trail_bad++;
            if (rises != 17) len_bad++;
        end
        if (!prev_sck && sck) begin
            rises++;
            if (rises == 1) begin
                if ((cyc - t_csfall) != DIV) lead_bad++;
            end else if ((cyc - t_edge) != DIV) hp_bad++;
            t_edge = cyc;
            if (rises <= 8) op_rx = {op_rx[6:0], mosi};
            else if (mosi !== 1'b0) tail_bad++;
            if (rises == 8 && op_rx != 8'h57) op_bad++;
        end
        if (prev_sck && !sck) begin
            if ((cyc - t_edge) != DIV) hp_bad++;
            t_edge = cyc;
            t_lastfall = cyc;
            if (rises == 8)                    miso = ~cur_resp()[7];
            else if (rises >= 9 && rises <= 16) miso = cur_resp()[16 - rises];
            else                               miso = ~rises[0];
        end
        if (sck && prev_sck && mosi != prev_mosi) mosi_bad++;
        if (cs_n && sck) cs_bad++;
        prev_sck  = sck;
        prev_cs   = cs_n;
        prev_mosi = mosi;
    end

    always @(negedge clk) begin
        if (cyc > WATCHDOG) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        frames = 0; gap_bad = 0; lead_bad = 0; trail_bad = 0; hp_bad = 0;
        len_bad = 0; op_bad = 0; mosi_bad = 0; cs_bad = 0; tail_bad = 0;
    endtask

    task automatic run_read(input bit poll, input int lim, output int done_width);
        int n = 0;
        clear_mon();
        @(negedge clk);
        poll_en = poll; try_limit = TW'(lim); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && n < 20000) begin @(negedge clk); n++; end
        done_width = 0;
        while (done && done_width < 5) begin done_width++; @(negedge clk); end
        repeat (2) @(negedge clk);
    endtask

    task automatic check_bus(input string tag);
        check(op_bad == 0,   {tag, " R2 opcode"}, op_bad, 0);
        check(mosi_bad == 0 && tail_bad == 0, {tag, " R2 mosi timing"}, mosi_bad + tail_bad, 0);
        check(len_bad == 0,  {tag, " R3 frame length"}, len_bad, 0);
        check(hp_bad == 0 && cs_bad == 0, {tag, " R4 half period"}, hp_bad + cs_bad, 0);
        check(lead_bad == 0 && trail_bad == 0, {tag, " R5 cs lead/trail"}, lead_bad + trail_bad, 0);
    endtask

    task automatic t_reset();
        check(cs_n == 1 && sck == 0 && mosi == 0, "R1 bus idle", {cs_n, sck, mosi}, 4);
        check(busy == 0 && done == 0 && status == 0, "R1 status idle", status, 0);
        check({ready, cmp_flag, density_bad, timeout} == 0, "R1 flags", {ready, cmp_flag, density_bad, timeout}, 0);
    endtask

    task automatic t_single(input logic [7:0] r, input bit exp_dbad, input string tag);
        int w;
        resp[0] = r;
        run_read(1'b0, 0, w);
        check(w == 1, {tag, " R8 done width"}, w, 1);
        check(frames == 1, {tag, " R10 single attempt"}, frames, 1);
        check(status == r, {tag, " R3 R11 status"}, status, r);
        check(ready == r[7] && cmp_flag == r[6], {tag, " R6 flags"}, {ready, cmp_flag}, r[7:6]);
        check(density_bad == exp_dbad, {tag, " R7 density"}, density_bad, exp_dbad);
        check(timeout == 0, {tag, " R10 no timeout"}, timeout, 0);
        check_bus(tag);
    endtask

    task automatic t_poll_ready();
        int w;
        resp[0] = 8'h20; resp[1] = 8'h27; resp[2] = 8'hE0;
        run_read(1'b1, 5, w);
        check(frames == 3, "R9 attempts until ready", frames, 3);
        check(gap_bad == 0, "R9 cs gap", gap_bad, 0);
        check(ready == 1 && timeout == 0 && status == 8'hE0, "R9 final status", status, 8'hE0);
        check_bus("poll");
    endtask

    task automatic t_poll_timeout();
        int w;
        for (int i = 0; i < 8; i++) resp[i] = 8'h60;
        run_read(1'b1, 3, w);
        check(frames == 3, "R10 attempts at limit", frames, 3);
        check(timeout == 1 && ready == 0, "R10 timeout flag", timeout, 1);
        check(gap_bad == 0, "R9 cs gap on timeout", gap_bad, 0);
        run_read(1'b1, 0, w);
        check(frames == 1, "R10 limit zero acts as one", frames, 1);
        check(timeout == 1, "R10 limit zero timeout", timeout, 1);
    endtask

    task automatic t_start_ignored();
        logic [7:0] held;
        int n = 0;
        resp[0] = 8'hA5;
        clear_mon();
        @(negedge clk);
        poll_en = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (25) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && n < 20000) begin @(negedge clk); n++; end
        held = status;
        repeat (40) @(negedge clk);
        check(frames == 1 && busy == 0, "R8 start while busy ignored", frames, 1);
        check(status == held && held == 8'hA5, "R8 status held", status, 8'hA5);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) resp[i] = 8'h00;
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single(8'hA0, 1'b0, "plain ready");
        t_single(8'hE7, 1'b0, "low bits set");
        t_single(8'hA0 | 8'h07, 1'b0, "low bits only");
        t_single(8'h58, 1'b1, "density mismatch");
        t_single(8'h20, 1'b0, "busy no poll");
        t_poll_ready();
        t_poll_timeout();
        t_start_ignored();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule